// File: doc/BRIEF.md
# Interrupt Aggregator with NMI Routing

This block collects single-bit interrupt requests from peripheral sources, synchronizes them into the core clock domain and presents a registered 19-line IRQ vector to a processor. Line 8 merges two sources. Lines 3, 14 and 16 are reserved and never assert. Software can find out which source raised a line by reading a per-line identity register. It can also copy any one populated line onto a non-maskable interrupt output.

For bring-up and for software tests there is a test mode. In test mode every peripheral request is blocked, and IRQ lines 0 to 15 are driven from a test register instead. Each write to the test register toggles the bits written with 1. A byte-key unlock sequence protects the test-mode bit, so a stray write cannot enter or leave test mode.

All access goes through a simple register port. The port takes a byte address whose two low bits are ignored. Writes take effect at the clock edge that samples them, and reads return data combinationally.

Top module: `irq_hub`

## Requirements
- R1: After reset, `irq_out` and `nmi_out` are 0, and the control (0x80), test (0x84), lock (0x8C) and identity registers all read 0.
- R2: In normal mode, source `src_req[n]` (n = 0..18) drives `irq_out[n]`. A change at the inputs first shows on `irq_out` after the third rising clock edge (two synchronizer flops and one output register).
- R3: Line 8 is the OR of `src_req[8]` and `src_req[19]`. Its identity register (0x20) shows `src_req[8]` in bit 0 and `src_req[19]` in bit 1.
- R4: The identity register of line n sits at byte offset 4·n. Bit 0 holds the synchronized source, and unused bits read 0. Lines 3, 14 and 16 read 0 at every bit and never assert on `irq_out`, whatever their inputs do.
- R5: The control register holds the NMI select in bits [4:0]. When it names a populated line, `nmi_out` equals that line of `irq_out` in the same cycle, and a change of the select takes effect one cycle after the write.
- R6: When the NMI select is above 18 or names line 3, 14 or 16, `nmi_out` is 0.
- R7: The test-mode bit (control bit 7) changes only while unlocked. Unlocking takes byte writes of 0x59, 0x16 and 0x88 in that order to `wdata[7:0]` at the lock register (0x8C). Any out-of-order byte returns the sequence to its start. While locked, writes to 0x80 still update the NMI select.
- R8: The lock register reads 1 while unlocked and 0 otherwise. Once open, a write of any byte other than 0x59 locks it again.
- R9: In test mode, peripheral requests have no effect. `irq_out[15:0]` equals the test register one cycle after it is written, and `irq_out[18:16]` is 0.
- R10: A write to the test register (0x84) toggles each bit of [15:0] that is written with 1 and leaves bits written with 0 unchanged. Bits 3 and 14 stay 0, and data bits [31:16] are ignored.
- R11: Writes to identity or undefined offsets change no state, and reads of undefined offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 20 | Peripheral requests; bit n feeds line n, bit 19 is the second source of line 8 |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 19 | Registered IRQ vector to the core |
| nmi_out | output | 1 | Registered non-maskable interrupt |

## Verification
The hardest state to reach is test mode with the peripheral inputs held high. Getting there means the full three-key unlock, a control write while unlocked, and then a relock, because the test register must be shown to own the outputs while the lock is closed again. The bench first shows that a locked write and an out-of-order key sequence leave the test-mode bit clear. It then unlocks, enters test mode, relocks and toggles the test register, including the reserved bits. Afterwards it unlocks again to return to normal mode, and checks that the synchronized peripheral state comes back on the next cycle.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned IRQ_N  = 19;
  localparam int unsigned SRC_N  = 20;
  localparam int unsigned TEST_N = 16;
  localparam int unsigned SEL_W  = 5;
  localparam int unsigned ID_W   = 3;
  localparam int unsigned DUAL_LINE = 8;
  localparam int unsigned DUAL_SRC  = 19;

  localparam logic [7:0] KEY_A = 8'h59;
  localparam logic [7:0] KEY_B = 8'h16;
  localparam logic [7:0] KEY_C = 8'h88;

  typedef enum logic [1:0] {LK_IDLE, LK_GOT_A, LK_GOT_B, LK_OPEN} lock_st_e;

  function automatic logic line_reserved(int n);
    return (n == 3) || (n == 14) || (n == 16);
  endfunction

  function automatic logic nmi_sel_ok(logic [SEL_W-1:0] s);
    return (int'(s) < IRQ_N) && !line_reserved(int'(s));
  endfunction

  function automatic logic [TEST_N-1:0] test_mask();
    logic [TEST_N-1:0] m;
    for (int i = 0; i < TEST_N; i++) m[i] = !line_reserved(i);
    return m;
  endfunction

  function automatic logic [ID_W-1:0] ident_bits(int n, logic [SRC_N-1:0] s);
    logic [ID_W-1:0] v;
    v = '0;
    if (!line_reserved(n) && n < IRQ_N) begin
      v[0] = s[n];
      if (n == DUAL_LINE) v[1] = s[DUAL_SRC];
    end
    return v;
  endfunction
endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
  parameter int unsigned W      = 20,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/irq_hub_lock.sv
module irq_hub_lock
  import irq_hub_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_byte,
  output logic       unlocked
);
  lock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_we) begin
      unique case (st_q)
        LK_IDLE:  st_d = (key_byte == KEY_A) ? LK_GOT_A : LK_IDLE;
        LK_GOT_A: st_d = (key_byte == KEY_B) ? LK_GOT_B : LK_IDLE;
        LK_GOT_B: st_d = (key_byte == KEY_C) ? LK_OPEN  : LK_IDLE;
        LK_OPEN:  st_d = (key_byte == KEY_A) ? LK_OPEN  : LK_IDLE;
        default:  st_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_IDLE;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == LK_OPEN);
endmodule

// File: rtl/irq_hub_route.sv
module irq_hub_route
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_sync,
  input  logic              test_mode,
  input  logic [TEST_N-1:0] test_reg,
  input  logic [SEL_W-1:0]  nmi_sel,
  output logic [IRQ_N-1:0]  irq_q,
  output logic              nmi_q
);
  logic [IRQ_N-1:0] agg;
  logic             nmi_d;

  always_comb begin
    for (int n = 0; n < IRQ_N; n++) begin
      if (test_mode) agg[n] = (n < TEST_N) ? (test_reg[n] && !line_reserved(n)) : 1'b0;
      else           agg[n] = |ident_bits(n, src_sync);
    end
    nmi_d = nmi_sel_ok(nmi_sel) ? agg[nmi_sel] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      nmi_q <= 1'b0;
    end else begin
      irq_q <= agg;
      nmi_q <= nmi_d;
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [IRQ_N-1:0]  irq_out,
  output logic              nmi_out
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(32);
  localparam logic [IDX_W-1:0] TEST_IDX = IDX_W'(33);
  localparam logic [IDX_W-1:0] LOCK_IDX = IDX_W'(35);
  localparam int unsigned TM_BIT = 7;

  logic [IDX_W-1:0]  idx;
  logic [SRC_N-1:0]  src_sync;
  logic [SEL_W-1:0]  sel_q;
  logic              tm_q;
  logic [TEST_N-1:0] treg_q;
  logic              unlocked_w;
  logic              ctrl_we_w, test_we_w, lock_we_w;
  logic              unused_bits;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign ctrl_we_w = bus_we && (idx == CTRL_IDX);
  assign test_we_w = bus_we && (idx == TEST_IDX);
  assign lock_we_w = bus_we && (idx == LOCK_IDX);
  assign unused_bits = ^{bus_wdata[DATA_W-1:TEST_N], bus_addr[1:0]};

  irq_hub_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_req), .q(src_sync)
  );

  irq_hub_lock u_lock (
    .clk(clk), .rst_n(rst_n), .key_we(lock_we_w),
    .key_byte(bus_wdata[7:0]), .unlocked(unlocked_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      tm_q   <= 1'b0;
      treg_q <= '0;
    end else begin
      if (ctrl_we_w) begin
        sel_q <= bus_wdata[SEL_W-1:0];
        if (unlocked_w) tm_q <= bus_wdata[TM_BIT];
      end
      if (test_we_w) treg_q <= treg_q ^ (bus_wdata[TEST_N-1:0] & test_mask());
    end
  end

  irq_hub_route u_route (
    .clk(clk), .rst_n(rst_n), .src_sync(src_sync), .test_mode(tm_q),
    .test_reg(treg_q), .nmi_sel(sel_q), .irq_q(irq_out), .nmi_q(nmi_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (int'(idx) < IRQ_N)    bus_rdata[ID_W-1:0] = ident_bits(int'(idx), src_sync);
    else if (idx == CTRL_IDX) begin
      bus_rdata[SEL_W-1:0] = sel_q;
      bus_rdata[TM_BIT]    = tm_q;
    end
    else if (idx == TEST_IDX) bus_rdata[TEST_N-1:0] = treg_q;
    else if (idx == LOCK_IDX) bus_rdata[0] = unlocked_w;
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [IRQ_N-1:0]  irq_out,
  input logic              nmi_out,
  input logic [SEL_W-1:0]  sel_w,
  input logic              tm_w,
  input logic [TEST_N-1:0] treg_w,
  input logic              unlocked_w
);
  p_rsv_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out[3] && !irq_out[14] && !irq_out[16]);

  p_nmi_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_sel_ok(sel_w) |=> (nmi_out == irq_out[$past(sel_w)]));

  p_nmi_bad_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_sel_ok(sel_w) |=> !nmi_out);

  p_tm_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_w != $past(tm_w)) |-> $past(unlocked_w));

  p_test_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tm_w |=> (irq_out[TEST_N-1:0] == $past(treg_w)) && (irq_out[IRQ_N-1:TEST_N] == '0));
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .nmi_out(nmi_out),
  .sel_w(sel_q), .tm_w(tm_q), .treg_w(treg_q), .unlocked_w(unlocked_w)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [19:0] src_req = '0;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [18:0] irq_out;
  logic        nmi_out;

  int n_chk = 0;
  int n_bad = 0;

  irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .nmi_out(nmi_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit rsv(int n);
    return n == 3 || n == 14 || n == 16;
  endfunction

  // Expected normal-mode IRQ vector from raw sources
  function automatic logic [18:0] exp_norm(logic [19:0] s);
    logic [18:0] v = '0;
    for (int n = 0; n < 19; n++) if (!rsv(n)) v[n] = s[n];
    v[8] = s[8] | s[19];
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = '0;
  endtask

  task automatic unlock();
    wr(8'h8C, 32'h59); wr(8'h8C, 32'h16); wr(8'h8C, 32'h88);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq_out), 0);
    check("R1 nmi", 32'(nmi_out), 0);
    rd(8'h80, d); check("R1 ctrl", d, 0);
    rd(8'h84, d); check("R1 test", d, 0);
    rd(8'h8C, d); check("R1 lock", d, 0);
    rd(8'h00, d); check("R1 ident0", d, 0);
  endtask

  task automatic t_pass();
    logic [31:0] d;
    src_req = 20'h00020;
    step(2); check("R2 latency not yet", 32'(irq_out), 0);
    step(1); check("R2 line5", 32'(irq_out), 32'(exp_norm(20'h00020)));
    rd(8'h14, d); check("R4 ident5", d, 1);
    src_req = 20'h7FFFF;
    step(3); check("R2 all lines", 32'(irq_out), 32'(exp_norm(20'h7FFFF)));
    rd(8'h0C, d); check("R4 reserved ident3", d, 0);
    rd(8'h40, d); check("R4 reserved ident16", d, 0);
    rd(8'h48, d); check("R4 ident18", d, 1);
  endtask

  task automatic t_line8();
    logic [31:0] d;
    src_req = 20'h80000;
    step(3); check("R3 line8 from second source", 32'(irq_out), 32'(1 << 8));
    rd(8'h20, d); check("R3 ident8 bit1", d, 2);
    src_req = 20'h80100;
    step(3); rd(8'h20, d); check("R3 ident8 both", d, 3);
    src_req = 20'h00100;
    step(3); rd(8'h20, d); check("R3 ident8 bit0", d, 1);
  endtask

  task automatic t_nmi();
    src_req = 20'h7FFFF & ~20'h00400;
    step(3);
    wr(8'h80, 32'd5);  step(1); check("R5 nmi sel5", 32'(nmi_out), 1);
    wr(8'h80, 32'd10); step(1); check("R5 nmi sel10 low line", 32'(nmi_out), 0);
    wr(8'h80, 32'd18); step(1); check("R5 nmi sel18", 32'(nmi_out), 1);
    wr(8'h80, 32'd3);  step(1); check("R6 nmi reserved sel", 32'(nmi_out), 0);
    wr(8'h80, 32'd16); step(1); check("R6 nmi reserved sel16", 32'(nmi_out), 0);
    wr(8'h80, 32'd25); step(1); check("R6 nmi sel out of range", 32'(nmi_out), 0);
    wr(8'h80, 32'd0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(8'h80, 32'h85); rd(8'h80, d); check("R7 locked write keeps tm", d, 32'h05);
    wr(8'h8C, 32'h59); wr(8'h8C, 32'h88); wr(8'h8C, 32'h16);
    rd(8'h8C, d); check("R7 wrong order stays locked", d, 0);
    wr(8'h80, 32'h80); rd(8'h80, d); check("R7 tm after bad seq", d, 0);
    unlock(); rd(8'h8C, d); check("R8 lock reads 1", d, 1);
    wr(8'h8C, 32'h59); rd(8'h8C, d); check("R8 key A keeps open", d, 1);
    wr(8'h80, 32'h82); rd(8'h80, d); check("R7 tm set unlocked", d, 32'h82);
    wr(8'h8C, 32'h00); rd(8'h8C, d); check("R8 relock", d, 0);
  endtask

  task automatic t_test();
    logic [31:0] d;
    src_req = 20'hFFFFF;
    step(3); check("R9 peripherals blocked", 32'(irq_out), 0);
    wr(8'h84, 32'h0021); step(1); check("R9 test drives irq", 32'(irq_out), 32'h21);
    wr(8'h84, 32'h0001); step(1); check("R10 toggle clears", 32'(irq_out), 32'h20);
    wr(8'h84, 32'h0000); step(1); check("R10 zero no effect", 32'(irq_out), 32'h20);
    wr(8'h84, 32'hFFFF4008); rd(8'h84, d); check("R10 reserved and upper ignored", d, 32'h20);
    wr(8'h84, 32'h8000); step(1); check("R9 line15 and 16-18 low", 32'(irq_out), 32'h8020);
    wr(8'h80, 32'h00); rd(8'h80, d); check("R7 locked clear ignored", d, 32'h80);
    unlock(); wr(8'h80, 32'h00); wr(8'h8C, 32'h01);
    step(1); check("R9 back to normal", 32'(irq_out), 32'(exp_norm(20'hFFFFF)));
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr(8'h80, 32'h07);
    wr(8'h14, 32'hFFFF); rd(8'h14, d); check("R11 ident write ignored", d, 1);
    wr(8'h90, 32'hFFFF); rd(8'h80, d); check("R11 undefined write", d, 32'h07);
    rd(8'h84, d); check("R11 test reg kept", d, 32'h8020);
    rd(8'h90, d); check("R11 undefined read", d, 0);
    rd(8'h88, d); check("R11 gap read", d, 0);
  endtask

  initial begin
    fork
      begin
        step(3); #1 rst_n = 1;
        step(1);
        t_reset(); t_pass(); t_line8(); t_nmi(); t_lock(); t_test(); t_ignore();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule